// File: doc/BRIEF.md
# Pipeline Event-Transfer Injection Controller

This block turns a set of hardware request flags into short data moves that borrow one slot of a four-stage fetch/decode/execute/writeback pipeline. Once a flag has been pending for a full cycle, a priority round runs among the enabled, armed sources. The winner's transfer is pushed into decode as a pseudo-instruction. The instruction that was about to enter decode waits for one cycle. In the following cycle the move runs on a small internal bus, copying one word or byte from the channel's source pointer to its destination pointer.

Each channel has a configuration entry with a source pointer, a destination pointer, an 8-bit remaining-transfer count and a byte/word select. A channel whose count is exhausted gets no transfer. It raises a one-cycle completion interrupt instead. When the instruction in execute reads a transfer control register, the round is skipped and retried in the next cycle. The pipeline itself is modelled by sequential instruction tags, so the sequencing can be observed at the ports.

Top module: `etx_inject_ctrl`

## Requirements
- R1: Synchronous active-low reset clears every pending flag, the count and pointer state, the arbitration state and the inject state. All four stage tags read 0. After release, the fetch tag rises by 1 every cycle while no transfer is active.
- R2: A `req_set_i` bit that is high in cycle k makes the flag pending in cycle k+1. The round runs in cycle k+2, and `inject_o` is high in cycle k+3, so the transfer starts two cycles after the flag is set.
- R3: In the inject cycle the winner's bit of `pend_o` reads 0. The decode tag reads 0, which marks the transfer slot. The fetch tag has moved on to N+2, while N+1 waits outside decode.
- R4: In the cycle after injection, `xfer_exec_o` is high and the fetch tag does not change. Decode shows the held instruction N+1.
- R5: Instructions reach execute and writeback in program order N, transfer, N+1, N+2, with no tag lost or repeated.
- R6: When `xfer_exec_o` is high, the bus reads `bus_raddr_o` = source pointer and writes `bus_waddr_o` = destination pointer. `bus_wdata_o` equals `bus_rdata_i` in word mode. In byte mode it carries `bus_rdata_i[7:0]` zero-extended, and `bus_byte_o` is 1. When no transfer executes, all bus outputs are 0.
- R7: A round selects the armed, enabled source with the greatest `ch_prio_i` value. A tie goes to the lower channel index. A disabled source stays pending and is never selected, and once it is enabled it wins in that same cycle and is injected the next cycle.
- R8: A round is not granted in any cycle in which `ex_rd_ctrl_i` is high. It is retried in the next cycle, so each such cycle delays injection by one cycle.
- R9: A winner with a non-zero count is injected and its count drops by 1. A winner with count 0 is not injected. Its flag is cleared, and its `done_irq_o` bit pulses for exactly the cycle in which injection would have happened.
- R10: At most one transfer is in flight. No round is granted while `inject_o` or `xfer_exec_o` is high, and requests raised meanwhile stay pending in `pend_o`.
- R11: When a channel's flag is set and cleared on the same edge, the set wins and the flag stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set_i | input | NUM_CH | One-cycle pulses that raise request flags |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_prio_i | input | NUM_CH*PRIO_W | Per-channel priority, channel 0 in the low bits |
| ex_rd_ctrl_i | input | 1 | Execute stage reads a transfer control register this cycle |
| cfg_we_i | input | 1 | Write one channel's configuration entry |
| cfg_ch_i | input | CH_W | Channel written |
| cfg_cnt_i | input | CNT_W | Remaining-transfer count |
| cfg_byte_i | input | 1 | 1 = byte transfer, 0 = word transfer |
| cfg_src_i | input | ADDR_W | Source pointer |
| cfg_dst_i | input | ADDR_W | Destination pointer |
| pend_o | output | NUM_CH | Pending request flags |
| done_irq_o | output | NUM_CH | Completion interrupt pulses |
| inject_o | output | 1 | Transfer slot occupies decode |
| xfer_exec_o | output | 1 | Transfer slot executes on the bus |
| tag_f_o | output | TAG_W | Fetch-stage tag |
| tag_d_o | output | TAG_W | Decode-stage tag (0 for the transfer slot) |
| tag_e_o | output | TAG_W | Execute-stage tag (0 for the transfer slot) |
| tag_w_o | output | TAG_W | Writeback-stage tag |
| bus_re_o | output | 1 | Bus read strobe |
| bus_raddr_o | output | ADDR_W | Bus read address |
| bus_rdata_i | input | DATA_W | Bus read data |
| bus_we_o | output | 1 | Bus write strobe |
| bus_waddr_o | output | ADDR_W | Bus write address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_byte_o | output | 1 | Byte-size bus access |

## Verification
Results fall due at fixed distances from a request pulse. The flag is visible after one cycle. The decode slot appears after three cycles, or after four when the control-register read collides with the round. The bus move and the resumed instruction follow one cycle after the slot, and a completion interrupt takes the slot's place at three cycles. The bench drives inputs and samples outputs only on falling edges. Its timing tasks count falling edges from the pulse, so each of these latencies is measured as an exact cycle number. In addition, a behavioural model steps on each rising edge and is compared with every output on every falling edge.

// File: rtl/etx_pkg.sv
// Shared definitions for the event-transfer injection controller.
// Assumes tags are small sequence numbers; tag value 0 inside a transfer slot
// is only meaningful together with the slot's xfer flag.
package etx_pkg;
    localparam int TAG_W = 8;

    // One decode/execute stage entry: transfer slot marker plus instruction tag.
    typedef struct packed {
        logic             xfer;
        logic [TAG_W-1:0] tag;
    } stage_t;

    // What the modelled pipeline does on the next edge.
    typedef enum logic [1:0] {
        PIPE_RUN    = 2'd0,
        PIPE_INJECT = 2'd1,
        PIPE_RESUME = 2'd2
    } pipe_act_e;
endpackage

// File: rtl/etx_arbiter.sv
// Priority pick among armed request sources.
// Does: returns the candidate with the greatest priority value, and the lowest
// index among equals. Assumes the caller has already masked the candidates
// with enable and arming. Purely combinational; clk/rst_n feed assertions only.
module etx_arbiter #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        cand_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    output logic                     valid_o,
    output logic [CH_W-1:0]          idx_o
);
    logic [PRIO_W-1:0] best;

    // Scan upward; a later source wins only with a strictly greater priority.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cand_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
                valid_o = 1'b1;
                idx_o   = CH_W'(i);
                best    = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    a_r7_winner_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cand_i[idx_o]);

    a_r7_any_cand_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand_i) |-> valid_o);

    for (genvar j = 0; j < NUM_CH; j++) begin : g_prio_chk
        a_r7_no_higher_loser: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_o && cand_i[j]) |->
            (prio_i[j*PRIO_W +: PRIO_W] < prio_i[idx_o*PRIO_W +: PRIO_W]) ||
            ((prio_i[j*PRIO_W +: PRIO_W] == prio_i[idx_o*PRIO_W +: PRIO_W]) &&
             (CH_W'(j) >= idx_o)));
    end
endmodule

// File: rtl/etx_channels.sv
// Per-channel request flags and configuration entries.
// Does: holds pending flags (set wins over clear), an arming bit that marks a
// flag as pending for at least one full cycle, the remaining-transfer count,
// the byte select and both pointers. Assumes clear and decrement name the same
// channel (the round winner).
module etx_channels #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_set_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    input  logic                     cfg_we_i,
    input  logic [CH_W-1:0]          cfg_ch_i,
    input  logic [CNT_W-1:0]         cfg_cnt_i,
    input  logic                     cfg_byte_i,
    input  logic [ADDR_W-1:0]        cfg_src_i,
    input  logic [ADDR_W-1:0]        cfg_dst_i,
    input  logic                     clr_i,
    input  logic                     dec_i,
    input  logic [CH_W-1:0]          sel_i,
    output logic [NUM_CH-1:0]        pend_o,
    output logic [NUM_CH-1:0]        cand_o,
    output logic [NUM_CH-1:0]        cnt_zero_o,
    output logic [NUM_CH-1:0]        byte_o,
    output logic [NUM_CH*ADDR_W-1:0] src_o,
    output logic [NUM_CH*ADDR_W-1:0] dst_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic              pend_q;
        logic              armed_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              byte_q;
        logic [ADDR_W-1:0] src_q;
        logic [ADDR_W-1:0] dst_q;
        logic              hit;

        assign hit = (sel_i == CH_W'(g));

        // Request flag: a new set wins over a clear on the same edge.
        always_ff @(posedge clk) begin
            if (!rst_n)                 pend_q <= 1'b0;
            else if (req_set_i[g])      pend_q <= 1'b1;
            else if (clr_i && hit)      pend_q <= 1'b0;
        end

        // Arming: the flag must have been pending in the previous cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) armed_q <= 1'b0;
            else        armed_q <= pend_q;
        end

        // Count: software load wins, else one decrement per started transfer.
        always_ff @(posedge clk) begin
            if (!rst_n)                                cnt_q <= '0;
            else if (cfg_we_i && cfg_ch_i == CH_W'(g)) cnt_q <= cfg_cnt_i;
            else if (dec_i && hit)                     cnt_q <= cnt_q - 1'b1;
        end

        // Pointers and size select, loaded as one configuration entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= 1'b0;
                src_q  <= '0;
                dst_q  <= '0;
            end else if (cfg_we_i && cfg_ch_i == CH_W'(g)) begin
                byte_q <= cfg_byte_i;
                src_q  <= cfg_src_i;
                dst_q  <= cfg_dst_i;
            end
        end

        assign pend_o[g]                 = pend_q;
        assign cand_o[g]                 = pend_q & armed_q & ch_en_i[g];
        assign cnt_zero_o[g]             = (cnt_q == '0);
        assign byte_o[g]                 = byte_q;
        assign src_o[g*ADDR_W +: ADDR_W] = src_q;
        assign dst_o[g*ADDR_W +: ADDR_W] = dst_q;

        a_r9_dec_only_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_i && hit && !(cfg_we_i && cfg_ch_i == CH_W'(g))) |-> (cnt_q != '0));

        a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            req_set_i[g] |=> pend_q);
    end
endmodule

// File: rtl/etx_pipe.sv
// Tag model of a fetch/decode/execute/writeback pipeline with slot injection.
// Does: advances one tag per cycle; on start_i it puts a transfer slot into
// decode and parks the fetched instruction; the next cycle the slot moves to
// execute and the parked instruction enters decode while fetch holds.
// Assumes start_i is never raised while a slot is in decode.
module etx_pipe
    import etx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [TAG_W-1:0] tag_f_o,
    output logic [TAG_W-1:0] tag_d_o,
    output logic [TAG_W-1:0] tag_e_o,
    output logic [TAG_W-1:0] tag_w_o,
    output logic             d_xfer_o,
    output logic             e_xfer_o
);
    logic [TAG_W-1:0] f_q;
    logic [TAG_W-1:0] hold_q;
    logic [TAG_W-1:0] w_q;
    stage_t           d_q;
    stage_t           e_q;
    pipe_act_e        act;

    // Choose this cycle's pipeline motion.
    always_comb begin
        if (d_q.xfer)    act = PIPE_RESUME;
        else if (start_i) act = PIPE_INJECT;
        else             act = PIPE_RUN;
    end

    // Stage registers; writeback always takes the execute tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            hold_q <= '0;
            d_q    <= '0;
            e_q    <= '0;
            w_q    <= '0;
        end else begin
            w_q <= e_q.tag;
            unique case (act)
                PIPE_INJECT: begin
                    e_q    <= d_q;
                    d_q    <= '{xfer: 1'b1, tag: '0};
                    hold_q <= f_q;
                    f_q    <= f_q + 1'b1;
                end
                PIPE_RESUME: begin
                    e_q <= d_q;
                    d_q <= '{xfer: 1'b0, tag: hold_q};
                end
                default: begin
                    e_q <= d_q;
                    d_q <= '{xfer: 1'b0, tag: f_q};
                    f_q <= f_q + 1'b1;
                end
            endcase
        end
    end

    assign tag_f_o  = f_q;
    assign tag_d_o  = d_q.tag;
    assign tag_e_o  = e_q.tag;
    assign tag_w_o  = w_q;
    assign d_xfer_o = d_q.xfer;
    assign e_xfer_o = e_q.xfer;

    a_r3_start_fills_decode: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> d_xfer_o && (tag_f_o == $past(tag_f_o) + 1'b1));

    a_r4_resume_next: assert property (@(posedge clk) disable iff (!rst_n)
        d_xfer_o |=> e_xfer_o && !d_xfer_o && $stable(tag_f_o));

    a_r1_fetch_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_xfer_o && !start_i) |=> (tag_f_o == $past(tag_f_o) + 1'b1));
endmodule

// File: rtl/etx_inject_ctrl.sv
// Event-transfer injection controller (top).
// Does: gates the priority round so that only one transfer is in flight and
// no round runs while execute reads a control register; starts a transfer or
// raises a completion interrupt for the winner; drives the one-cycle bus move
// from the executing slot. Assumes bus reads return data in the same cycle.
module etx_inject_ctrl #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 4,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int TAG_W = etx_pkg::TAG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_set_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio_i,
    input  logic                     ex_rd_ctrl_i,
    input  logic                     cfg_we_i,
    input  logic [CH_W-1:0]          cfg_ch_i,
    input  logic [CNT_W-1:0]         cfg_cnt_i,
    input  logic                     cfg_byte_i,
    input  logic [ADDR_W-1:0]        cfg_src_i,
    input  logic [ADDR_W-1:0]        cfg_dst_i,
    output logic [NUM_CH-1:0]        pend_o,
    output logic [NUM_CH-1:0]        done_irq_o,
    output logic                     inject_o,
    output logic                     xfer_exec_o,
    output logic [TAG_W-1:0]         tag_f_o,
    output logic [TAG_W-1:0]         tag_d_o,
    output logic [TAG_W-1:0]         tag_e_o,
    output logic [TAG_W-1:0]         tag_w_o,
    output logic                     bus_re_o,
    output logic [ADDR_W-1:0]        bus_raddr_o,
    input  logic [DATA_W-1:0]        bus_rdata_i,
    output logic                     bus_we_o,
    output logic [ADDR_W-1:0]        bus_waddr_o,
    output logic [DATA_W-1:0]        bus_wdata_o,
    output logic                     bus_byte_o
);
    logic [NUM_CH-1:0]        cand;
    logic [NUM_CH-1:0]        cnt_zero;
    logic [NUM_CH-1:0]        byte_sel;
    logic [NUM_CH*ADDR_W-1:0] src_all;
    logic [NUM_CH*ADDR_W-1:0] dst_all;
    logic                     arb_valid;
    logic [CH_W-1:0]          arb_idx;
    logic                     grant;
    logic                     start;
    logic [CH_W-1:0]          xch_q;
    logic [NUM_CH-1:0]        done_q;

    etx_channels #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_set_i  (req_set_i),
        .ch_en_i    (ch_en_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_ch_i   (cfg_ch_i),
        .cfg_cnt_i  (cfg_cnt_i),
        .cfg_byte_i (cfg_byte_i),
        .cfg_src_i  (cfg_src_i),
        .cfg_dst_i  (cfg_dst_i),
        .clr_i      (grant),
        .dec_i      (start),
        .sel_i      (arb_idx),
        .pend_o     (pend_o),
        .cand_o     (cand),
        .cnt_zero_o (cnt_zero),
        .byte_o     (byte_sel),
        .src_o      (src_all),
        .dst_o      (dst_all)
    );

    etx_arbiter #(
        .NUM_CH(NUM_CH), .PRIO_W(PRIO_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand_i  (cand),
        .prio_i  (ch_prio_i),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    etx_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tag_f_o  (tag_f_o),
        .tag_d_o  (tag_d_o),
        .tag_e_o  (tag_e_o),
        .tag_w_o  (tag_w_o),
        .d_xfer_o (inject_o),
        .e_xfer_o (xfer_exec_o)
    );

    // Round is granted only with no slot in flight and no control-register read.
    assign grant = arb_valid && !inject_o && !xfer_exec_o && !ex_rd_ctrl_i;
    assign start = grant && !cnt_zero[arb_idx];

    // Remember the winning channel for the bus move one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)     xch_q <= '0;
        else if (grant) xch_q <= arb_idx;
    end

    // Completion interrupt takes the slot's cycle when the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n)                          done_q <= '0;
        else if (grant && cnt_zero[arb_idx]) done_q <= NUM_CH'(1) << arb_idx;
        else                                 done_q <= '0;
    end

    assign done_irq_o = done_q;

    // Bus move of the executing slot; idle outputs are held at zero.
    always_comb begin
        bus_re_o    = 1'b0;
        bus_we_o    = 1'b0;
        bus_byte_o  = 1'b0;
        bus_raddr_o = '0;
        bus_waddr_o = '0;
        bus_wdata_o = '0;
        if (xfer_exec_o) begin
            bus_re_o    = 1'b1;
            bus_we_o    = 1'b1;
            bus_byte_o  = byte_sel[xch_q];
            bus_raddr_o = src_all[xch_q*ADDR_W +: ADDR_W];
            bus_waddr_o = dst_all[xch_q*ADDR_W +: ADDR_W];
            bus_wdata_o = byte_sel[xch_q] ? DATA_W'(bus_rdata_i[7:0]) : bus_rdata_i;
        end
    end

    a_r8_no_inject_after_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inject_o) |-> !$past(ex_rd_ctrl_i));

    a_r10_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !(inject_o && xfer_exec_o));

    a_r9_one_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_irq_o) && !(|done_irq_o && inject_o));

    a_r6_bus_pair: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_exec_o |-> bus_re_o && bus_we_o);
endmodule

// File: tb/tb_etx_inject_ctrl.sv
module tb_etx_inject_ctrl;
    localparam int N = 4;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req_set = '0;
    logic [N-1:0] ch_en = '1;
    logic [N*P-1:0] ch_prio = '0;
    logic        ex_rd = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [7:0]  cfg_cnt = '0;
    logic        cfg_byte = 1'b0;
    logic [15:0] cfg_src = '0;
    logic [15:0] cfg_dst = '0;
    logic [N-1:0] pend, done_irq;
    logic        inject, xexec;
    logic [7:0]  tf, td, te, tw;
    logic        bre, bwe, bbyte;
    logic [15:0] braddr, bwaddr, bwdata, brdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign brdata = braddr ^ 16'hA5C3;

    etx_inject_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .ch_en_i(ch_en),
        .ch_prio_i(ch_prio), .ex_rd_ctrl_i(ex_rd), .cfg_we_i(cfg_we),
        .cfg_ch_i(cfg_ch), .cfg_cnt_i(cfg_cnt), .cfg_byte_i(cfg_byte),
        .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .pend_o(pend),
        .done_irq_o(done_irq), .inject_o(inject), .xfer_exec_o(xexec),
        .tag_f_o(tf), .tag_d_o(td), .tag_e_o(te), .tag_w_o(tw),
        .bus_re_o(bre), .bus_raddr_o(braddr), .bus_rdata_i(brdata),
        .bus_we_o(bwe), .bus_waddr_o(bwaddr), .bus_wdata_o(bwdata),
        .bus_byte_o(bbyte)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_pend = '0, m_arm = '0, m_done = '0, m_byte = '0;
    int           m_cnt[N];
    logic [15:0]  m_src[N], m_dst[N];
    logic [7:0]   m_f = '0, m_d = '0, m_e = '0, m_w = '0, m_hold = '0;
    bit           m_dx = 0, m_ex = 0;
    int           m_xch = 0;

    always @(posedge clk) begin
        bit bv, g, st;
        int bi, bp;
        logic [N-1:0] old_pend;
        cyc++;
        if (!rst_n) begin
            m_pend = '0; m_arm = '0; m_done = '0; m_byte = '0;
            m_f = 0; m_d = 0; m_e = 0; m_w = 0; m_hold = 0;
            m_dx = 0; m_ex = 0; m_xch = 0;
            for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_src[i] = 0; m_dst[i] = 0; end
        end else begin
            bv = 0; bi = 0; bp = -1;
            for (int i = 0; i < N; i++)
                if (m_pend[i] && m_arm[i] && ch_en[i] && int'(ch_prio[i*P +: P]) > bp) begin
                    bv = 1; bi = i; bp = int'(ch_prio[i*P +: P]);
                end
            g  = bv && !m_dx && !m_ex && !ex_rd;
            st = g && (m_cnt[bi] != 0);
            m_w = m_e;
            if (m_dx) begin
                m_e = 0; m_ex = 1; m_dx = 0; m_d = m_hold;
            end else if (st) begin
                m_e = m_d; m_ex = 0; m_d = 0; m_dx = 1; m_hold = m_f; m_f = m_f + 1;
            end else begin
                m_e = m_d; m_ex = 0; m_d = m_f; m_f = m_f + 1;
            end
            m_done = (g && m_cnt[bi] == 0) ? (N'(1) << bi) : '0;
            if (g) m_xch = bi;
            for (int i = 0; i < N; i++) begin
                if (cfg_we && int'(cfg_ch) == i) begin
                    m_cnt[i] = cfg_cnt; m_byte[i] = cfg_byte;
                    m_src[i] = cfg_src; m_dst[i] = cfg_dst;
                end else if (st && i == bi) m_cnt[i] = m_cnt[i] - 1;
            end
            old_pend = m_pend;
            m_arm = old_pend;
            for (int i = 0; i < N; i++)
                if (req_set[i]) m_pend[i] = 1;
                else if (g && i == bi) m_pend[i] = 0;
        end
    end

    // Compare every output against the model in the middle of each cycle.
    always @(negedge clk) begin
        logic [15:0] er, ew, ewd;
        bit eb;
        er = m_ex ? m_src[m_xch] : 16'h0;
        ew = m_ex ? m_dst[m_xch] : 16'h0;
        eb = m_ex ? m_byte[m_xch] : 1'b0;
        ewd = !m_ex ? 16'h0 : eb ? {8'h0, (er ^ 16'hA5C3) & 16'h00FF} : (er ^ 16'hA5C3);
        check(pend == m_pend, "R3 pend", pend, m_pend);
        check(done_irq == m_done, "R9 done_irq", done_irq, m_done);
        check(inject == m_dx, "R2 inject", inject, m_dx);
        check(xexec == m_ex, "R4 xfer_exec", xexec, m_ex);
        check({tf, td} == {m_f, m_d}, "R4 fetch/decode tags", {tf, td}, {m_f, m_d});
        check({te, tw} == {m_e, m_w}, "R5 execute/writeback tags", {te, tw}, {m_e, m_w});
        check({bre, bwe, bbyte} == {m_ex, m_ex, eb}, "R6 bus strobes", {bre, bwe, bbyte}, {m_ex, m_ex, eb});
        check({braddr, bwaddr, bwdata} == {er, ew, ewd}, "R6 bus addr/data",
              {braddr, bwaddr, bwdata}, {er, ew, ewd});
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg(input int ch, input int cnt, input bit byt, input logic [15:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_ch = 2'(ch); cfg_cnt = 8'(cnt); cfg_byte = byt; cfg_src = s; cfg_dst = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse one request, optionally collide a control-register read at cycle
    // offset conf_at, and return the offset at which inject_o is first seen.
    task automatic pulse_time(input int ch, input int conf_at, output int n);
        req_set = N'(1) << ch;
        n = 0;
        while (n < 20) begin
            @(negedge clk);
            n++;
            req_set = '0;
            if (inject) break;
            ex_rd = (n == conf_at);
        end
        ex_rd = 0;
    endtask

    initial begin
        int n;
        logic [15:0] seq[$];
        bit saw;

        repeat (3) @(negedge clk);
        check(tf == 0 && td == 0 && te == 0 && tw == 0, "R1 reset tags", {tf, td, te, tw}, 0);
        check(pend == 0 && !inject && !xexec, "R1 reset flags", {pend, inject, xexec}, 0);
        rst_n = 1;
        @(negedge clk);
        @(negedge clk);
        check(tf == 8'd2, "R1 free-running fetch", tf, 2);

        for (int i = 0; i < N; i++) cfg(i, 5, i == 1, 16'h0100 + 16'(i), 16'h0200 + 16'(i));
        idle(3);

        // R2: nominal response of three cycles from pulse to decode slot.
        pulse_time(0, 0, n);
        check(n == 3, "R2 inject latency", n, 3);
        check(pend[0] == 0 && td == 0, "R3 flag cleared, slot in decode", {pend[0], td}, 0);
        idle(6);

        // R8: a control-register read during the round delays by one cycle.
        pulse_time(0, 2, n);
        check(n == 4, "R8 conflict retry latency", n, 4);
        idle(6);

        // R7: priority value first, lowest index on a tie.
        ch_prio = {4'd1, 4'd5, 4'd5, 4'd3};
        req_set = 4'b0111;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            req_set = '0;
            if (xexec) seq.push_back(braddr);
        end
        check(seq.size() == 3, "R7 transfer count", seq.size(), 3);
        if (seq.size() == 3) begin
            check(seq[0] == 16'h0101, "R7 highest priority, low index", seq[0], 16'h0101);
            check(seq[1] == 16'h0102, "R7 tie loser second", seq[1], 16'h0102);
            check(seq[2] == 16'h0100, "R7 lowest priority last", seq[2], 16'h0100);
        end
        ch_prio = '0;
        idle(4);

        // R7: a disabled source stays pending and wins once enabled.
        ch_en = 4'b1011;
        req_set = 4'b0100;
        saw = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            req_set = '0;
            if (inject) saw = 1;
        end
        check(!saw && pend[2], "R7 disabled not selected", {saw, pend[2]}, 1);
        ch_en = '1;
        n = 0;
        while (n < 10) begin @(negedge clk); n++; if (inject) break; end
        check(n == 1, "R7 enabled source injected next cycle", n, 1);
        idle(6);

        // R9: an exhausted channel raises its completion pulse instead.
        cfg(3, 0, 0, 16'h0103, 16'h0203);
        idle(2);
        req_set = 4'b1000;
        saw = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            req_set = '0;
            if (inject) saw = 1;
            if (k == 3) check(done_irq == 4'b1000, "R9 done pulse at slot cycle", done_irq, 4'b1000);
            if (k == 4) check(done_irq == 4'b0000, "R9 done pulse one cycle", done_irq, 0);
        end
        check(!saw && !pend[3], "R9 no transfer, flag cleared", {saw, pend[3]}, 0);

        // R9: count of one allows exactly one transfer, then completion.
        cfg(0, 1, 0, 16'h0100, 16'h0200);
        idle(2);
        pulse_time(0, 0, n);
        check(n == 3, "R9 last transfer injected", n, 3);
        idle(6);
        req_set = 4'b0001;
        saw = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            req_set = '0;
            if (inject) saw = 1;
            if (k == 3) check(done_irq == 4'b0001, "R9 completion after count spent", done_irq, 1);
        end
        check(!saw, "R9 no transfer at count zero", saw, 0);
        cfg(0, 5, 0, 16'h0100, 16'h0200);
        idle(4);

        // R10: a request raised during injection waits for the next round.
        req_set = 4'b0001;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            req_set = '0;
            if (k == 3) begin
                check(inject, "R10 first slot", inject, 1);
                req_set = 4'b0010;
            end
            if (k == 4) check(pend[1], "R10 new request held pending", pend[1], 1);
            if (k == 6) check(inject, "R10 second slot after first completes", inject, 1);
        end
        idle(6);

        // R11: a set on the clearing edge keeps the flag pending.
        req_set = 4'b0001;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            req_set = (k == 2) ? 4'b0001 : 4'b0000;
            if (k == 3) check(pend[0] && inject, "R11 set wins over clear", {pend[0], inject}, 2'b11);
        end
        idle(12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule